// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in. The adder is split into four 4-bit groups. Each group forms a generate and a propagate term for every bit. From these it derives its own internal carries as flat sum-of-products expressions, and it reports one group propagate and one group generate term. A second-level lookahead unit takes the four pairs of group terms and the carry-in. It produces the carry into each group directly, so no carry ever ripples from one group to the next. Sum bits are then the exclusive-or of the two operand bits and the carry into that position.

Beyond the sum and the carry-out, the block also reports a whole-word propagate and a whole-word generate term. A higher lookahead level can use these to treat this adder as one group of a wider adder. The result is captured in an output register on each rising clock edge. It therefore appears one cycle after the operands are presented. An active-low asynchronous reset clears that register.

Top module: `cla16_adder`

## Requirements
- R1: One clock edge after the operands and carry-in are sampled, sum_o equals the low 16 bits of a_i + b_i + cin_i, taken as unsigned values.
- R2: On that same edge, cout_o equals bit 16 of the unsigned sum a_i + b_i + cin_i.
- R3: prop_o is 1 exactly when every bit position holds a 1 in at least one of the operands, meaning (a_i OR b_i) is all ones.
- R4: gen_o is 1 exactly when a_i + b_i, taken without the carry-in, produces a carry out of bit 15.
- R5: gen_o set forces cout_o set. When gen_o is clear and prop_o is set, cout_o equals the carry-in that was sampled.
- R6: While rst_n is low, sum_o, cout_o, prop_o and gen_o are all 0. The clear takes effect at once, without waiting for a clock edge.
- R7: A carry-in of 1 reaches every group in the same cycle. For example, a_i = 16'hFFFF, b_i = 0, cin_i = 1 gives sum_o = 0 and cout_o = 1.
- R8: Results depend only on the operands. Swapping a_i and b_i leaves all four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Registered sum |
| cout_o | output | 1 | Registered carry out of bit 15 |
| prop_o | output | 1 | Registered whole-word propagate term |
| gen_o | output | 1 | Registered whole-word generate term |

## Verification
The properties assume that operands and carry-in are known, non-X values at every rising edge once reset is released. Because the block is purely arithmetic, they accept any pattern of change from one cycle to the next. The stimulus drives inputs only on falling edges and holds each vector across exactly one rising edge. It never leaves an input undriven after reset is released. Reset is released on a falling edge, so the first edge out of reset always sees a settled vector.

// File: rtl/cla16_pkg.sv
package cla16_pkg;

    // Default geometry of the adder: bits per lookahead group and group count.
    localparam int DEF_GRP_W = 4;
    localparam int DEF_N_GRP = 4;

endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over W generate/propagate pairs.
// Used both inside a group (bit terms) and as the second level (group terms).
module cla_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W-1:0] carry_o,
    output logic         blk_prop_o,
    output logic         blk_gen_o
);

    // carry_o[i] is the carry into position i. Each carry is formed as its own
    // product-sum from the terms below it, with no reuse of earlier carries.
    always_comb begin
        carry_o[0] = cin_i;
        for (int i = 1; i < W; i++) begin
            logic acc;
            logic term;
            acc = cin_i;
            for (int k = 0; k < i; k++) begin
                acc = acc & prop_i[k];
            end
            for (int j = 0; j < i; j++) begin
                term = gen_i[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & prop_i[k];
                end
                acc = acc | term;
            end
            carry_o[i] = acc;
        end
    end

    // Block terms are independent of the carry-in.
    always_comb begin
        logic acc;
        logic term;
        blk_prop_o = &prop_i;
        acc = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = gen_i[j];
            for (int k = j + 1; k < W; k++) begin
                term = term & prop_i[k];
            end
            acc = acc | term;
        end
        blk_gen_o = acc;
    end

endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit terms, in-group carries, sum bits, group terms.
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         blk_prop_o,
    output logic         blk_gen_o
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_carry;

    always_comb begin
        bit_gen  = a_i & b_i;
        bit_prop = a_i | b_i;
    end

    cla_lookahead #(
        .W (W)
    ) la_i (
        .gen_i      (bit_gen),
        .prop_i     (bit_prop),
        .cin_i      (cin_i),
        .carry_o    (bit_carry),
        .blk_prop_o (blk_prop_o),
        .blk_gen_o  (blk_gen_o)
    );

    always_comb begin
        sum_o = a_i ^ b_i ^ bit_carry;
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
    parameter int GRP_W  = cla16_pkg::DEF_GRP_W,
    parameter int N_GRP  = cla16_pkg::DEF_N_GRP,
    parameter int DATA_W = GRP_W * N_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              prop_o,
    output logic              gen_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              cout;
        logic              prop;
        logic              gen;
    } cla_out_t;

    logic [N_GRP-1:0]  grp_prop;
    logic [N_GRP-1:0]  grp_gen;
    logic [N_GRP-1:0]  grp_cin;
    logic [DATA_W-1:0] sum_w;
    logic              top_prop;
    logic              top_gen;

    cla_out_t out_d;
    cla_out_t out_q;

    // First level: one lookahead group per slice.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        cla_group #(
            .W (GRP_W)
        ) grp_i (
            .a_i        (a_i[g*GRP_W +: GRP_W]),
            .b_i        (b_i[g*GRP_W +: GRP_W]),
            .cin_i      (grp_cin[g]),
            .sum_o      (sum_w[g*GRP_W +: GRP_W]),
            .blk_prop_o (grp_prop[g]),
            .blk_gen_o  (grp_gen[g])
        );
    end

    // Second level: carry into every group from the group terms.
    cla_lookahead #(
        .W (N_GRP)
    ) top_la_i (
        .gen_i      (grp_gen),
        .prop_i     (grp_prop),
        .cin_i      (cin_i),
        .carry_o    (grp_cin),
        .blk_prop_o (top_prop),
        .blk_gen_o  (top_gen)
    );

    always_comb begin
        out_d      = out_q;
        out_d.sum  = sum_w;
        out_d.cout = top_gen | (top_prop & cin_i);
        out_d.prop = top_prop;
        out_d.gen  = top_gen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        sum_o  = out_q.sum;
        cout_o = out_q.cout;
        prop_o = out_q.prop;
        gen_o  = out_q.gen;
    end

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              cin_i,
    input logic [DATA_W-1:0] sum_o,
    input logic              cout_o,
    input logic              prop_o,
    input logic              gen_o
);

    logic [DATA_W:0] full_ref;
    logic [DATA_W:0] raw_ref;
    logic            all_prop_ref;

    always_comb begin
        full_ref     = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        raw_ref      = {1'b0, a_i} + {1'b0, b_i};
        all_prop_ref = &(a_i | b_i);
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sum_o == $past(full_ref[DATA_W-1:0])); // R1

    AST_COUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cout_o == $past(full_ref[DATA_W])); // R2

    AST_PROP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prop_o == $past(all_prop_ref)); // R3

    AST_GEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> gen_o == $past(raw_ref[DATA_W])); // R4

    AST_GEN_FORCES_COUT: assert property (@(posedge clk) disable iff (!rst_n)
        gen_o |-> cout_o); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_o == '0 && !cout_o && !prop_o && !gen_o)); // R6

endmodule

bind cla16_adder cla16_adder_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .prop_o (prop_o),
    .gen_o  (gen_o)
);

// File: tb/cla16_adder_tb_top.sv
`timescale 1ns/1ps
module cla16_adder_tb_top;

    localparam int DW = 16;
    localparam int N_VEC = 12;
    localparam int N_RAND = 400;

    // Each entry: {a, b, cin}
    localparam logic [2*DW:0] VEC [N_VEC] = '{
        {16'h0000, 16'h0000, 1'b0},
        {16'h0000, 16'h0000, 1'b1},
        {16'hFFFF, 16'h0000, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b0},
        {16'h8000, 16'h8000, 1'b0},
        {16'h000F, 16'h0001, 1'b0},
        {16'h00FF, 16'h0001, 1'b0},
        {16'h0FFF, 16'h0000, 1'b1},
        {16'hAAAA, 16'h5555, 1'b0},
        {16'hAAAA, 16'h5555, 1'b1},
        {16'h1234, 16'h4321, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic          cin = 1'b0;
    logic [DW-1:0] sum;
    logic          cout;
    logic          prop;
    logic          gen;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cla16_adder dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout),
        .prop_o (prop),
        .gen_o  (gen)
    );

    task automatic check(input string req, input logic [DW:0] got, input logic [DW:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)", req, got, exp, a, b, cin);
        end
    endtask

    task automatic apply_and_check(input logic [DW-1:0] va, input logic [DW-1:0] vb, input logic vc);
        logic [DW:0] full;
        logic [DW:0] raw;
        a = va; b = vb; cin = vc;
        full = {1'b0, va} + {1'b0, vb} + {{DW{1'b0}}, vc};
        raw  = {1'b0, va} + {1'b0, vb};
        @(negedge clk);
        check("R1 sum", {1'b0, sum}, {1'b0, full[DW-1:0]});
        check("R2 cout", {{DW{1'b0}}, cout}, {{DW{1'b0}}, full[DW]});
        check("R3 prop", {{DW{1'b0}}, prop}, {{DW{1'b0}}, &(va | vb)});
        check("R4 gen", {{DW{1'b0}}, gen}, {{DW{1'b0}}, raw[DW]});
        if (gen) check("R5 gen->cout", {{DW{1'b0}}, cout}, {{DW{1'b0}}, 1'b1});
        if (!gen && prop) check("R5 prop passes cin", {{DW{1'b0}}, cout}, {{DW{1'b0}}, vc});
    endtask

    task automatic check_zero(input string req);
        check(req, {cout, sum}, '0);
        check(req, {{(DW-1){1'b0}}, prop, gen}, '0);
    endtask

    initial begin
        logic [DW-1:0] lfsr;
        logic [DW-1:0] sa;
        logic [DW-1:0] sb;
        logic [DW:0]   s1;
        logic [DW:0]   s2;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check_zero("R6 reset state");
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            apply_and_check(VEC[i][2*DW:DW+1], VEC[i][DW:1], VEC[i][0]);
        end

        // R7: carry-in crosses all four groups in one cycle
        apply_and_check(16'hFFFF, 16'h0000, 1'b1);
        check("R7 full carry chain sum", {1'b0, sum}, '0);
        check("R7 full carry chain cout", {{DW{1'b0}}, cout}, {{DW{1'b0}}, 1'b1});

        // Pseudo-random vectors from a Galois LFSR
        for (int i = 0; i < N_RAND; i++) begin
            lfsr = {1'b0, lfsr[DW-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            sa = lfsr;
            lfsr = {1'b0, lfsr[DW-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            sb = lfsr;
            apply_and_check(sa, sb, lfsr[3]);
        end

        // R8: operand swap gives identical outputs
        apply_and_check(16'h3C5A, 16'hC3F0, 1'b1);
        s1 = {cout, sum};
        apply_and_check(16'hC3F0, 16'h3C5A, 1'b1);
        s2 = {cout, sum};
        check("R8 operand swap", s2, s1);

        // R6: asynchronous clear in the middle of operation
        apply_and_check(16'hFFFF, 16'hFFFF, 1'b1);
        #2 rst_n = 1'b0;
        #1 check_zero("R6 async clear");
        @(negedge clk);
        check_zero("R6 held in reset");
        rst_n = 1'b1;
        apply_and_check(16'h7FFF, 16'h0001, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule